// File: doc/BRIEF.md
# MII Management Port with Embedded PHY Register Model

This block is the station-management side of an Ethernet MAC. It does not drive a serial management line. It keeps a model of one PHY's 32 sixteen-bit registers, and answers management traffic from that model. Software writes three MAC-side registers through a simple write port: a management address (register and PHY number), a control-data word, and a command. A write to the control-data register stores the word in the addressed PHY register. A command with its read bit set copies the addressed PHY register into the management status output.

Only one PHY address is populated, and it is set by a parameter. Traffic to any other PHY address writes nothing and reads back zero. The model behaves like a simple copper PHY. It has power-up defaults and a soft reset that clears itself. Auto-negotiation finishes the moment it is requested. The negotiation-complete and link bits of the PHY status register follow a `link_up` input from the system.

Top module: `mii_mgmt_top`

## Requirements
- R1: The write port selects a target with `wr_sel`: 0 is the management address, 1 is control data and 2 is the command. On an address write, `wr_data[4:0]` is the PHY register number and `wr_data[12:8]` is the PHY address.
- R2: A command write with `wr_data[0]`=1 loads the addressed PHY register into `mgmt_status`, visible one clock later. A command write with bit 0 clear leaves `mgmt_status` unchanged.
- R3: A read command whose PHY address differs from `PHY_ADDR` loads 0 into `mgmt_status`.
- R4: A control-data write whose PHY address differs from `PHY_ADDR` changes no PHY register.
- R5: A control-data write to the matching PHY stores `wr_data` in the addressed register, except where R7 and R8 say otherwise.
- R6: After hardware reset, `mgmt_status` is 0 and every PHY register is 0 except the following: register 0 = 0x1140, register 1 = 0x7948 (link bits clear), register 2 = 0x0022, register 3 = 0x1550, register 4 = 0x01E1 and register 5 = 0xCDE1.
- R7: A control-data write to register 0 with bit 15 set performs a PHY soft reset. Every register is reloaded with the R6 defaults, the link bits are then applied from `link_up`, and bit 15 is never stored.
- R8: A control-data write to register 0 with bit 12 set stores the word with bit 12 cleared and sets bit 5 (negotiation complete) of register 1.
- R9: When `link_up` differs from its value in the previous cycle, bits 5 and 2 of register 1 are both set (link up) or both cleared (link down) at the next clock edge.
- R10: After a soft reset with the link down, register 1 reads 0x7948. With the link up it reads 0x796C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the management registers |
| wr_sel | input | 2 | Target register: 0 address, 1 control data, 2 command, 3 none |
| wr_data | input | 16 | Write data |
| link_up | input | 1 | Link state reported by the system |
| mgmt_status | output | 16 | Result of the last read command |

## Verification
The hardest cases are those where two mechanisms update register 1 in an order that matters. One is a soft reset or auto-negotiation request issued while the link is down. Another is a link change that closes a soft reset sequence. These cases are reached through directed sequences: the bench toggles `link_up`, then issues control writes carrying bits 15 and 12, then reads back through the normal command path. A long seeded random run follows. It mixes address writes aimed at the real and foreign PHY addresses, control writes with random data and link toggles, and every read is compared with a bench model.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
    localparam int DW     = 16;
    localparam int RIDX_W = 5;
    localparam int NREG   = 1 << RIDX_W;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_CMD   = 2'd2,
        SEL_NONE  = 2'd3
    } mgmt_sel_e;

    localparam int IDX_CTL  = 0;
    localparam int IDX_STAT = 1;

    localparam int CTL_RST_BIT  = 15;
    localparam int CTL_ANEN_BIT = 12;
    localparam int ST_ANOK_BIT  = 5;
    localparam int ST_LINK_BIT  = 2;

    function automatic logic [DW-1:0] phy_default(input int idx);
        case (idx)
            0:       return 16'h1140;
            1:       return 16'h7968;
            2:       return 16'h0022;
            3:       return 16'h1550;
            4:       return 16'h01E1;
            5:       return 16'hCDE1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] link_apply(input logic [DW-1:0] st, input logic up);
        logic [DW-1:0] r;
        r = st;
        r[ST_ANOK_BIT] = up;
        r[ST_LINK_BIT] = up;
        return r;
    endfunction
endpackage

// File: rtl/mii_field_split.sv
module mii_field_split
    import mii_mgmt_pkg::*;
#(
    parameter int REG_LSB = 0,
    parameter int PHY_LSB = 8
) (
    input  logic [DW-1:0]     word,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [RIDX_W-1:0] phy_idx
);
    logic unused_bits;
    assign unused_bits = ^{word[15:13], word[7:5]};
    assign reg_idx = word[REG_LSB +: RIDX_W];
    assign phy_idx = word[PHY_LSB +: RIDX_W];
endmodule

// File: rtl/mii_ctl_filter.sv
module mii_ctl_filter
    import mii_mgmt_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic          is_ctl,
    output logic [DW-1:0] store_val,
    output logic          soft_rst,
    output logic          an_done
);
    always_comb begin
        store_val = data;
        soft_rst  = is_ctl && data[CTL_RST_BIT];
        an_done   = is_ctl && data[CTL_ANEN_BIT];
        if (is_ctl) begin
            store_val[CTL_RST_BIT]  = 1'b0;
            store_val[CTL_ANEN_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/mii_read_mux.sv
module mii_read_mux
    import mii_mgmt_pkg::*;
(
    input  logic [NREG-1:0][DW-1:0] regs,
    input  logic [RIDX_W-1:0]       idx,
    input  logic                    hit,
    output logic [DW-1:0]           value
);
    assign value = hit ? regs[idx] : '0;
endmodule

// File: rtl/mii_mgmt_top.sv
module mii_mgmt_top
    import mii_mgmt_pkg::*;
#(
    parameter logic [RIDX_W-1:0] PHY_ADDR = 5'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          link_up,
    output logic [DW-1:0] mgmt_status
);
    typedef struct packed {
        logic [RIDX_W-1:0]       reg_idx;
        logic [RIDX_W-1:0]       phy_idx;
        logic [DW-1:0]           wdata;
        logic [DW-1:0]           status;
        logic                    link;
        logic [NREG-1:0][DW-1:0] regs;
    } state_t;

    state_t state_d, state_q;

    logic [RIDX_W-1:0] new_reg, new_phy;
    logic              phy_hit;
    logic [DW-1:0]     store_val, rd_val;
    logic              soft_rst, an_done;
    logic [DW-1:0]     view_ctl, view_stat, view_id1;

    assign phy_hit = (state_q.phy_idx == PHY_ADDR);

    mii_field_split u_split (
        .word    (wr_data),
        .reg_idx (new_reg),
        .phy_idx (new_phy)
    );

    mii_ctl_filter u_filt (
        .data      (wr_data),
        .is_ctl    (state_q.reg_idx == RIDX_W'(IDX_CTL)),
        .store_val (store_val),
        .soft_rst  (soft_rst),
        .an_done   (an_done)
    );

    mii_read_mux u_rmux (
        .regs  (state_q.regs),
        .idx   (state_q.reg_idx),
        .hit   (phy_hit),
        .value (rd_val)
    );

    always_comb begin
        logic phy_wr;
        logic rd_cmd;
        state_d = state_q;
        phy_wr  = wr_en && (wr_sel == SEL_WDATA) && phy_hit;
        rd_cmd  = wr_en && (wr_sel == SEL_CMD) && wr_data[0];

        if (wr_en && (wr_sel == SEL_ADDR)) begin
            state_d.reg_idx = new_reg;
            state_d.phy_idx = new_phy;
        end
        if (wr_en && (wr_sel == SEL_WDATA)) begin
            state_d.wdata = wr_data;
        end
        if (rd_cmd) begin
            state_d.status = rd_val;
        end
        if (phy_wr) begin
            if (soft_rst) begin
                for (int i = 0; i < NREG; i++) begin
                    state_d.regs[i] = phy_default(i);
                end
                state_d.regs[IDX_STAT] = link_apply(phy_default(IDX_STAT), link_up);
            end
            if (an_done) begin
                state_d.regs[IDX_STAT][ST_ANOK_BIT] = 1'b1;
            end
            state_d.regs[state_q.reg_idx] = store_val;
        end
        if (link_up != state_q.link) begin
            state_d.regs[IDX_STAT] = link_apply(state_d.regs[IDX_STAT], link_up);
        end
        state_d.link = link_up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.reg_idx <= '0;
            state_q.phy_idx <= '0;
            state_q.wdata   <= '0;
            state_q.status  <= '0;
            state_q.link    <= 1'b0;
            for (int i = 0; i < NREG; i++) begin
                state_q.regs[i] <= (i == IDX_STAT) ? link_apply(phy_default(i), 1'b0)
                                                   : phy_default(i);
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign mgmt_status = state_q.status;
    assign view_ctl    = state_q.regs[IDX_CTL];
    assign view_stat   = state_q.regs[IDX_STAT];
    assign view_id1    = state_q.regs[2];
endmodule

// File: rtl/mii_mgmt_chk.sv
module mii_mgmt_chk
    import mii_mgmt_pkg::*;
#(
    parameter logic [RIDX_W-1:0] PHY_ADDR = 5'd1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DW-1:0]     wr_data,
    input logic              link_up,
    input logic [DW-1:0]     mgmt_status,
    input logic [RIDX_W-1:0] cur_phy,
    input logic [RIDX_W-1:0] cur_reg,
    input logic [DW-1:0]     phy_ctl,
    input logic [DW-1:0]     phy_stat,
    input logic [DW-1:0]     phy_id1
);
    // R6
    status_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> mgmt_status == '0);

    // R3
    foreign_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && wr_data[0] && cur_phy != PHY_ADDR) |=> mgmt_status == '0);

    // R4
    foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && cur_phy != PHY_ADDR) |=> phy_ctl == $past(phy_ctl));

    // R7
    soft_reset_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && cur_phy == PHY_ADDR && cur_reg == '0 && wr_data[15])
        |=> (phy_id1 == 16'h0022 && !phy_ctl[15]));

    // R8
    autoneg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && cur_phy == PHY_ADDR && cur_reg == '0 && wr_data[12]
         && link_up == $past(link_up))
        |=> (phy_stat[5] && !phy_ctl[12]));

    // R9
    link_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up != $past(link_up) && !wr_en)
        |=> (phy_stat[2] == $past(link_up) && phy_stat[5] == $past(link_up)));
endmodule

bind mii_mgmt_top mii_mgmt_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .link_up     (link_up),
    .mgmt_status (mgmt_status),
    .cur_phy     (state_q.phy_idx),
    .cur_reg     (state_q.reg_idx),
    .phy_ctl     (view_ctl),
    .phy_stat    (view_stat),
    .phy_id1     (view_id1)
);

// File: tb/sim_mii_mgmt_top.sv
`timescale 1ns/1ps
module sim_mii_mgmt_top;
    localparam logic [4:0] PHY = 5'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [15:0] wr_data = '0;
    logic        link_up = 1'b1;
    logic [15:0] mgmt_status;

    int vectors = 0;
    int miscompares = 0;

    logic [15:0] mreg [32];
    logic [4:0]  m_reg, m_phy;
    logic [15:0] m_stat;
    logic        m_link;

    always #2 clk = ~clk;

    mii_mgmt_top #(.PHY_ADDR(PHY)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .link_up(link_up), .mgmt_status(mgmt_status)
    );

    function automatic logic [15:0] dflt(input int i);
        case (i)
            0: return 16'h1140;
            1: return 16'h7968;
            2: return 16'h0022;
            3: return 16'h1550;
            4: return 16'h01E1;
            5: return 16'hCDE1;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] with_link(input logic [15:0] v, input logic up);
        logic [15:0] r;
        r = v;
        r[5] = up;
        r[2] = up;
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_phy_write(input logic [15:0] d);
        logic [15:0] v;
        v = d;
        if (m_phy != PHY) return;
        if (m_reg == 5'd0) begin
            if (v[15]) begin
                for (int i = 0; i < 32; i++) mreg[i] = dflt(i);
                mreg[1] = with_link(mreg[1], link_up);
                v[15] = 1'b0;
            end
            if (v[12]) begin
                v[12] = 1'b0;
                mreg[1][5] = 1'b1;
            end
        end
        mreg[m_reg] = v;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_sel = 2'd3;
        case (sel)
            2'd0: begin m_reg = d[4:0]; m_phy = d[12:8]; end
            2'd1: model_phy_write(d);
            2'd2: if (d[0]) m_stat = (m_phy == PHY) ? mreg[m_reg] : 16'h0;
            default: ;
        endcase
    endtask

    task automatic set_addr(input logic [4:0] phy, input logic [4:0] r);
        wr(2'd0, {3'b000, phy, 3'b000, r});
    endtask

    task automatic rd_expect(input string tag, input logic [15:0] exp);
        wr(2'd2, 16'h0001);
        check(tag, mgmt_status, exp);
    endtask

    task automatic set_link(input logic v);
        link_up = v;
        @(negedge clk);
        if (v != m_link) mreg[1] = with_link(mreg[1], v);
        m_link = v;
    endtask

    initial begin
        #(4ns * 150000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 32; i++) mreg[i] = dflt(i);
        mreg[1] = with_link(mreg[1], 1'b0);
        m_reg = '0; m_phy = '0; m_stat = '0; m_link = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: status output after reset
        check("R6 status after reset", mgmt_status, 16'h0000);
        @(negedge clk);
        mreg[1] = with_link(mreg[1], 1'b1);
        m_link = 1'b1;

        // R6 defaults (link has come up: R9)
        set_addr(PHY, 5'd1);
        rd_expect("R6 R9 status reg with link up", 16'h796C);
        for (int i = 0; i < 8; i++) begin
            if (i == 1) continue;
            set_addr(PHY, 5'(i));
            rd_expect("R6 default register", dflt(i));
        end

        // R1: field positions, junk in the unused bits
        wr(2'd0, {3'b111, PHY, 3'b111, 5'd4});
        rd_expect("R1 address fields", 16'h01E1);

        // R5: plain store
        set_addr(PHY, 5'd9);
        wr(2'd1, 16'hA5C3);
        rd_expect("R5 stored word", 16'hA5C3);

        // R2: command without read bit keeps status
        set_addr(PHY, 5'd2);
        wr(2'd2, 16'hFFFE);
        check("R2 no-read command keeps status", mgmt_status, 16'hA5C3);

        // R4: foreign write ignored
        set_addr(5'd7, 5'd9);
        wr(2'd1, 16'h1234);
        set_addr(5'd7, 5'd0);
        wr(2'd1, 16'h8000);
        set_addr(PHY, 5'd9);
        rd_expect("R4 foreign write ignored", 16'hA5C3);
        set_addr(PHY, 5'd2);
        rd_expect("R4 no reset through foreign PHY", 16'h0022);

        // R3: foreign read returns zero
        set_addr(5'd31, 5'd2);
        rd_expect("R3 foreign read", 16'h0000);

        // R9: link down
        set_link(1'b0);
        set_addr(PHY, 5'd1);
        rd_expect("R9 link down clears bits", 16'h7948);

        // R8: autoneg with link down
        set_addr(PHY, 5'd0);
        wr(2'd1, 16'h1000);
        rd_expect("R8 enable bit not stored", 16'h0000);
        set_addr(PHY, 5'd1);
        rd_expect("R8 negotiation complete set", 16'h7968);

        // R9: link up then down
        set_link(1'b1);
        rd_expect("R9 link up sets bits", 16'h796C);
        set_link(1'b0);
        rd_expect("R9 link down again", 16'h7948);

        // R7 and R10: soft reset with link up
        set_link(1'b1);
        set_addr(PHY, 5'd9);
        wr(2'd1, 16'h5555);
        set_addr(PHY, 5'd0);
        wr(2'd1, 16'h8000);
        rd_expect("R7 reset bit not stored", 16'h0000);
        set_addr(PHY, 5'd9);
        rd_expect("R7 other registers cleared", 16'h0000);
        set_addr(PHY, 5'd3);
        rd_expect("R7 ID reloaded", 16'h1550);
        set_addr(PHY, 5'd1);
        rd_expect("R10 soft reset link up", 16'h796C);

        // R10: soft reset with link down
        set_link(1'b0);
        set_addr(PHY, 5'd0);
        wr(2'd1, 16'h8140);
        set_addr(PHY, 5'd1);
        rd_expect("R10 soft reset link down", 16'h7948);
        set_link(1'b1);

        // random traffic checked against the model (R2 R5 R7 R8 R9)
        for (int n = 0; n < 600; n++) begin
            int op;
            op = $urandom % 7;
            case (op)
                0, 1: set_addr(($urandom % 4 == 0) ? 5'($urandom) : PHY,
                               ($urandom % 2 == 0) ? 5'($urandom % 8) : 5'($urandom));
                2: wr(2'd1, 16'($urandom));
                3: wr(2'd1, 16'($urandom) & 16'h6FFF);
                4: set_link(~link_up);
                default: rd_expect("R2 random read", (m_phy == PHY) ? mreg[m_reg] : 16'h0000);
            endcase
        end
        check("R2 final status", mgmt_status, m_stat);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule